// File: doc/BRIEF.md
# SPI Output-Driver Diagnostic Check Sequencer

This block sits on the host side of an SPI link to an octal low-side output driver. It checks the driver's channels for faults without any software help. A one-cycle `start` pulse hands it a control byte. In that byte a 0 switches a channel on and a 1 switches it off. The block writes the byte to the driver and then waits a settling interval, so that the driver's own fault logic can react to inrush and overload. It then writes the same byte a second time. During this second transfer it captures the diagnostic byte that the driver shifts back. Each returned bit is 1 when the channel pin is high.

The block compares each returned bit with the bit that was programmed and produces two masks. The short/overload mask marks channels that were switched on but still read high. The open-load mask marks channels that were switched off but read low. The block drives chip enable, the serial clock and the serial data line itself, and it samples the serial return line. The chip-enable lead time, the lag time, the clock high and low times and the settling wait are all given in nanoseconds. They are converted to system-clock cycles with rounding up, so every minimum is met at any clock period.

Top module: `diag_check_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `spi_cs_n` is 1, `spi_sclk` is 0, `done` is 0 and both masks are 0. A reset in the middle of a sequence aborts it the same way.
- R2: A `start` pulse in idle causes exactly two SPI transfers of 8 bits each. Both carry the control byte sampled with `start`, most significant bit first, and the driver latches that byte at each chip-enable rise.
- R3: In every transfer, `spi_cs_n` is low for at least ceil(LEAD_NS/period) cycles before the first `spi_sclk` rise. It stays low for at least ceil(LAG_NS/period) cycles after the last `spi_sclk` fall.
- R4: Every `spi_sclk` high phase lasts at least ceil(SCK_HI_NS/period) cycles. Every low phase between two rises lasts at least ceil(SCK_LO_NS/period) cycles.
- R5: `spi_sclk` is 0 in the cycle before and the cycle of every `spi_cs_n` change, and `spi_sclk` is never 1 while `spi_cs_n` is 1.
- R6: `spi_cs_n` stays high for at least ceil(SETTLE_NS/period) cycles between the end of the first transfer and the start of the second.
- R7: The masks are computed from the byte returned during the second transfer only. `spi_miso` is sampled while `spi_sclk` is high, and the first sampled bit goes to bit 7. The byte returned during the first transfer has no effect.
- R8: `short_mask[i]` is 1 exactly when control bit i is 0 (on) and returned bit i is 1.
- R9: `open_mask[i]` is 1 exactly when control bit i is 1 (off) and returned bit i is 0.
- R10: A channel whose returned bit equals its control bit is 0 in both masks, so the masks never share a set bit.
- R11: `done` is a one-cycle pulse. It comes one cycle after the second chip-enable rise, with both masks valid. The masks then hold until the next `done`.
- R12: A `start` pulse while a sequence is running is ignored. It causes no extra transfer, no extra `done` and no change to the byte being sent.
- R13: While `spi_cs_n` stays low, `spi_mosi` changes only in the cycle where `spi_sclk` rises. It is therefore stable across every falling edge, where the driver samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a check sequence |
| ctrl_byte | input | NBITS | Control byte (0 = channel on), sampled with `start` |
| spi_cs_n | output | 1 | Chip enable to the driver, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the driver |
| spi_miso | input | 1 | Serial diagnostic data from the driver |
| done | output | 1 | One-cycle pulse when the masks are valid |
| short_mask | output | NBITS | Channels switched on that read high |
| open_mask | output | NBITS | Channels switched off that read low |

## Verification
A behavioural driver model shifts bytes in on falling edges and out on rising edges. It returns one chosen byte for the first transfer and a different one for the second. The bench applies all-off and all-on bytes with clean returns, a full short and a full open, and alternating patterns in which every bit is wrong. It also applies a single mismatch at bit 7 or bit 0. Together these separate the two fault polarities from each other, detect bit-order and bit-offset errors, and would catch a design that reads the first return instead of the second. Further directed runs cover a start pulse during the settle wait and during a transfer, and a reset in the middle of a transfer. Monitors measure every chip-enable and clock phase against the rounded-up cycle minimums.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_LEAD,
    ENG_HIGH,
    ENG_LOW,
    ENG_LAG
  } eng_state_t;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_WRITE,
    SEQ_SETTLE,
    SEQ_CHECK
  } seq_state_t;

  // Nanoseconds to clock cycles, rounded up, never below one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dcs_spi_engine.sv
module dcs_spi_engine
  import dcs_pkg::*;
#(
  parameter int unsigned NBITS    = 8,
  parameter int unsigned LEAD_CYC = 32,
  parameter int unsigned LAG_CYC  = 32,
  parameter int unsigned HI_CYC   = 25,
  parameter int unsigned LO_CYC   = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NBITS-1:0] tx,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             fin,
  output logic [NBITS-1:0] rx
);

  localparam int unsigned MAXC = max2(max2(LEAD_CYC, LAG_CYC), max2(HI_CYC, LO_CYC));
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned BW   = $clog2(NBITS + 1);

  eng_state_t       state;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bits_done;
  logic [NBITS-1:0] tx_sh;
  logic [NBITS-1:0] rx_sh;

  assign rx = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      cnt       <= '0;
      bits_done <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      fin       <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (go) begin
            cs_n      <= 1'b0;
            mosi      <= tx[NBITS-1];
            tx_sh     <= {tx[NBITS-2:0], 1'b0};
            bits_done <= '0;
            cnt       <= CW'(LEAD_CYC - 1);
            state     <= ENG_LEAD;
          end
        end
        ENG_LEAD: begin
          if (cnt == '0) begin
            sclk  <= 1'b1;
            cnt   <= CW'(HI_CYC - 1);
            state <= ENG_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ENG_HIGH: begin
          if (cnt == '0) begin
            sclk      <= 1'b0;
            rx_sh     <= {rx_sh[NBITS-2:0], miso};
            bits_done <= bits_done + 1'b1;
            if (bits_done == BW'(NBITS - 1)) begin
              cnt   <= CW'(LAG_CYC - 1);
              state <= ENG_LAG;
            end else begin
              cnt   <= CW'(LO_CYC - 1);
              state <= ENG_LOW;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ENG_LOW: begin
          if (cnt == '0) begin
            sclk  <= 1'b1;
            mosi  <= tx_sh[NBITS-1];
            tx_sh <= {tx_sh[NBITS-2:0], 1'b0};
            cnt   <= CW'(HI_CYC - 1);
            state <= ENG_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ENG_LAG: begin
          if (cnt == '0) begin
            cs_n  <= 1'b1;
            mosi  <= 1'b0;
            fin   <= 1'b1;
            state <= ENG_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dcs_wait_timer.sv
module dcs_wait_timer #(
  parameter int unsigned CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        cnt     <= CW'(CYCLES - 1);
        running <= 1'b1;
      end else if (running) begin
        if (cnt == '0) begin
          running <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dcs_fault_decode.sv
module dcs_fault_decode #(
  parameter int unsigned NBITS = 8
) (
  input  logic [NBITS-1:0] ctrl,
  input  logic [NBITS-1:0] ret,
  output logic [NBITS-1:0] short_o,
  output logic [NBITS-1:0] open_o
);

  for (genvar i = 0; i < NBITS; i++) begin : g_ch
    // ctrl 0 = channel on: a high pin means it could not pull down.
    assign short_o[i] = ~ctrl[i] &  ret[i];
    // ctrl 1 = channel off: a low pin means nothing pulls it up.
    assign open_o[i]  =  ctrl[i] & ~ret[i];
  end

endmodule

// File: rtl/diag_check_seq.sv
module diag_check_seq
  import dcs_pkg::*;
#(
  parameter int unsigned NBITS         = 8,
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned LEAD_NS       = 250,
  parameter int unsigned LAG_NS        = 250,
  parameter int unsigned SCK_HI_NS     = 200,
  parameter int unsigned SCK_LO_NS     = 200,
  parameter int unsigned SETTLE_NS     = 160000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NBITS-1:0] ctrl_byte,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             done,
  output logic [NBITS-1:0] short_mask,
  output logic [NBITS-1:0] open_mask
);

  localparam int unsigned LEAD_CYC   = ns_to_cyc(LEAD_NS, CLK_PERIOD_PS);
  localparam int unsigned LAG_CYC    = ns_to_cyc(LAG_NS, CLK_PERIOD_PS);
  localparam int unsigned HI_CYC     = ns_to_cyc(SCK_HI_NS, CLK_PERIOD_PS);
  localparam int unsigned LO_CYC     = ns_to_cyc(SCK_LO_NS, CLK_PERIOD_PS);
  localparam int unsigned SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_PERIOD_PS);

  seq_state_t       state;
  logic [NBITS-1:0] ctrl_q;
  logic             eng_go;
  logic             eng_fin;
  logic [NBITS-1:0] eng_rx;
  logic             tmr_load;
  logic             tmr_expired;
  logic [NBITS-1:0] dec_short;
  logic [NBITS-1:0] dec_open;

  dcs_spi_engine #(
    .NBITS   (NBITS),
    .LEAD_CYC(LEAD_CYC),
    .LAG_CYC (LAG_CYC),
    .HI_CYC  (HI_CYC),
    .LO_CYC  (LO_CYC)
  ) i_engine (
    .clk (clk),
    .rst (rst),
    .go  (eng_go),
    .tx  (ctrl_q),
    .cs_n(spi_cs_n),
    .sclk(spi_sclk),
    .mosi(spi_mosi),
    .miso(spi_miso),
    .fin (eng_fin),
    .rx  (eng_rx)
  );

  dcs_wait_timer #(
    .CYCLES(SETTLE_CYC)
  ) i_settle (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .expired(tmr_expired)
  );

  dcs_fault_decode #(
    .NBITS(NBITS)
  ) i_decode (
    .ctrl   (ctrl_q),
    .ret    (eng_rx),
    .short_o(dec_short),
    .open_o (dec_open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      ctrl_q     <= '0;
      eng_go     <= 1'b0;
      tmr_load   <= 1'b0;
      done       <= 1'b0;
      short_mask <= '0;
      open_mask  <= '0;
    end else begin
      eng_go   <= 1'b0;
      tmr_load <= 1'b0;
      done     <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            ctrl_q <= ctrl_byte;
            eng_go <= 1'b1;
            state  <= SEQ_WRITE;
          end
        end
        SEQ_WRITE: begin
          if (eng_fin) begin
            tmr_load <= 1'b1;
            state    <= SEQ_SETTLE;
          end
        end
        SEQ_SETTLE: begin
          if (tmr_expired) begin
            eng_go <= 1'b1;
            state  <= SEQ_CHECK;
          end
        end
        SEQ_CHECK: begin
          if (eng_fin) begin
            short_mask <= dec_short;
            open_mask  <= dec_open;
            done       <= 1'b1;
            state      <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int unsigned NBITS    = 8,
  parameter int unsigned LEAD_CYC = 32,
  parameter int unsigned LAG_CYC  = 32,
  parameter int unsigned HI_CYC   = 25,
  parameter int unsigned LO_CYC   = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             spi_cs_n,
  input logic             spi_sclk,
  input logic             spi_mosi,
  input logic             done,
  input logic [NBITS-1:0] short_mask,
  input logic [NBITS-1:0] open_mask
);

  localparam int unsigned MIN_RISE_GAP = (LO_CYC < LEAD_CYC) ? LO_CYC : LEAD_CYC;

  logic [15:0] hi_cnt;
  logic [15:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      if (spi_sclk) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
      else          hi_cnt <= '0;
      if (!spi_sclk && !spi_cs_n) lo_cnt <= (lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1;
      else                        lo_cnt <= '0;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (spi_cs_n && !spi_sclk && !done));

  a_r3_lag: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> (lo_cnt >= 16'(LAG_CYC)));

  a_r4_high_width: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_sclk) |-> (hi_cnt >= 16'(HI_CYC)));

  a_r4_low_width: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |-> (lo_cnt >= 16'(MIN_RISE_GAP)));

  a_r5_sclk_needs_cs: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> !spi_cs_n);

  a_r5_cs_edge_sclk_low: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n != $past(spi_cs_n)) |-> (!spi_sclk && !$past(spi_sclk)));

  a_r10_masks_disjoint: assert property (@(posedge clk) disable iff (rst)
    done |-> ((short_mask & open_mask) == '0));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_done_after_cs: assert property (@(posedge clk) disable iff (rst)
    done |-> (spi_cs_n && $past(spi_cs_n)));

  a_r11_masks_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(short_mask) && $stable(open_mask)));

  a_r13_mosi_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
    ((spi_mosi != $past(spi_mosi)) && !spi_cs_n && !$past(spi_cs_n)) |-> $rose(spi_sclk));

endmodule

bind diag_check_seq dcs_checker #(
  .NBITS   (NBITS),
  .LEAD_CYC(LEAD_CYC),
  .LAG_CYC (LAG_CYC),
  .HI_CYC  (HI_CYC),
  .LO_CYC  (LO_CYC)
) i_dcs_checker (
  .clk       (clk),
  .rst       (rst),
  .spi_cs_n  (spi_cs_n),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .done      (done),
  .short_mask(short_mask),
  .open_mask (open_mask)
);

// File: tb/test_diag_check_seq.sv
`timescale 1ns/1ps
module test_diag_check_seq;

  localparam int PERIOD_PS = 8000;
  localparam int SETTLE_NS = 4000;
  // Expected minimums, rounded up by hand: 250ns->32, 200ns->25, 4000ns->500.
  localparam int LEAD_C   = 32;
  localparam int LAG_C    = 32;
  localparam int HI_C     = 25;
  localparam int LO_C     = 25;
  localparam int SETTLE_C = 500;

  // {ctrl, first return, second return, expected short, expected open}
  localparam logic [39:0] VEC [8] = '{
    {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00},
    {8'h00, 8'hFF, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00},
    {8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF},
    {8'hA5, 8'hA5, 8'h5A, 8'h5A, 8'hA5},
    {8'h0F, 8'h0F, 8'h1E, 8'h10, 8'h01},
    {8'h80, 8'h80, 8'h81, 8'h01, 8'h00},
    {8'h3C, 8'hC3, 8'h3C, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] ctrl_byte = '0;
  logic       spi_cs_n, spi_sclk, spi_mosi;
  logic       spi_miso = 1'b0;
  logic       done;
  logic [7:0] short_mask, open_mask;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  diag_check_seq #(
    .NBITS(8), .CLK_PERIOD_PS(PERIOD_PS), .LEAD_NS(250), .LAG_NS(250),
    .SCK_HI_NS(200), .SCK_LO_NS(200), .SETTLE_NS(SETTLE_NS)
  ) i_diag_check_seq (
    .clk(clk), .rst(rst), .start(start), .ctrl_byte(ctrl_byte),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .done(done), .short_mask(short_mask), .open_mask(open_mask)
  );

  // Driver model: load diagnostics on chip-enable fall, shift out on rise,
  // shift in on fall, latch on chip-enable rise.
  logic [7:0] dev_sr = '0;
  logic [7:0] ret_a = '0, ret_b = '0;
  logic [7:0] lat0 = '0, lat1 = '0;
  int         xfer_cnt = 0;
  int         seq_base = 0;
  logic       m_cs = 1'b1, m_sck = 1'b0;

  always @(spi_cs_n or spi_sclk) begin
    if (m_cs === 1'b1 && spi_cs_n === 1'b0)
      dev_sr = ((xfer_cnt - seq_base) == 0) ? ret_a : ret_b;
    if (m_cs === 1'b0 && spi_cs_n === 1'b1) begin
      if ((xfer_cnt - seq_base) == 0) lat0 = dev_sr;
      if ((xfer_cnt - seq_base) == 1) lat1 = dev_sr;
      xfer_cnt = xfer_cnt + 1;
    end
    if (m_sck === 1'b0 && spi_sclk === 1'b1 && spi_cs_n === 1'b0)
      spi_miso = dev_sr[7];
    if (m_sck === 1'b1 && spi_sclk === 1'b0 && spi_cs_n === 1'b0)
      dev_sr = {dev_sr[6:0], spi_mosi};
    m_cs  = spi_cs_n;
    m_sck = spi_sclk;
  end

  // Timing monitor, sampled away from the active edge.
  int   ev_cnt = 0;
  int   gap_cnt = 0;
  bit   first_rise = 1'b0;
  logic p_cs = 1'b1, p_sck = 1'b0, p_mosi = 1'b0;
  int   err_r3 = 0, err_r4 = 0, err_r5 = 0, err_r6 = 0, err_r13 = 0;
  int   done_cnt = 0;

  always @(negedge clk) begin
    if (rst) begin
      ev_cnt = 0; gap_cnt = 0; first_rise = 1'b0;
    end else begin
      ev_cnt++;
      gap_cnt++;
      if (done === 1'b1) done_cnt++;
      if (spi_cs_n === 1'b1 && spi_sclk === 1'b1) err_r5++;
      if (p_cs && !spi_cs_n) begin
        if (spi_sclk || p_sck) err_r5++;
        if ((xfer_cnt - seq_base) == 1 && gap_cnt < SETTLE_C + 1) err_r6++;
        first_rise = 1'b1; ev_cnt = 1;
      end else if (!p_cs && spi_cs_n) begin
        if (spi_sclk || p_sck) err_r5++;
        if (ev_cnt < LAG_C + 1) err_r3++;
        gap_cnt = 1; ev_cnt = 1;
      end else if (!spi_cs_n && !p_cs) begin
        if (spi_sclk && !p_sck) begin
          if (first_rise && ev_cnt < LEAD_C + 1) err_r3++;
          if (!first_rise && ev_cnt < LO_C + 1) err_r4++;
          first_rise = 1'b0; ev_cnt = 1;
        end else if (!spi_sclk && p_sck) begin
          if (ev_cnt < HI_C + 1) err_r4++;
          ev_cnt = 1;
        end
        if (spi_mosi !== p_mosi && !(spi_sclk && !p_sck)) err_r13++;
      end
    end
    p_cs = spi_cs_n; p_sck = spi_sclk; p_mosi = spi_mosi;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [7:0] c);
    @(negedge clk); start = 1'b1; ctrl_byte = c;
    @(negedge clk); start = 1'b0; ctrl_byte = 8'h00;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      @(negedge clk);
      if (done === 1'b1) seen = 1'b1;
    end
  endtask

  task automatic run_vec(input logic [39:0] v);
    bit seen;
    logic [7:0] c, es, eo;
    int dc0;
    c = v[39:32]; ret_a = v[31:24]; ret_b = v[23:16]; es = v[15:8]; eo = v[7:0];
    seq_base = xfer_cnt;
    dc0 = done_cnt;
    pulse_start(c);
    wait_done(seen);
    check(seen, "R11", "done seen", seen, 1);
    check(lat0 == c, "R2", "first write byte", lat0, c);
    check(lat1 == c, "R2", "second write byte", lat1, c);
    check(short_mask == es, "R8", "short mask", short_mask, es);
    check(open_mask == eo, "R9", "open mask", open_mask, eo);
    check((short_mask | open_mask) == (c ^ ret_b) && (short_mask & open_mask) == 0,
          "R10", "matching channels clear", short_mask | open_mask, c ^ ret_b);
    if (ret_a != ret_b)
      check(short_mask == es && open_mask == eo, "R7", "second return used",
            {short_mask, open_mask}, {es, eo});
    @(negedge clk);
    check(done === 1'b0, "R11", "done one cycle", done, 0);
    check(short_mask == es && open_mask == eo, "R11", "masks held",
          {short_mask, open_mask}, {es, eo});
    check(done_cnt == dc0 + 1, "R11", "single done", done_cnt - dc0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit seen;
    int dc0, x0;
    repeat (3) @(negedge clk);
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1", "bus idle in reset",
          {spi_cs_n, spi_sclk}, 2'b10);
    check(done === 1'b0 && short_mask == 0 && open_mask == 0, "R1", "outputs clear in reset",
          {done, short_mask, open_mask}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(spi_cs_n === 1'b1 && done === 1'b0, "R1", "idle after reset", {spi_cs_n, done}, 2'b10);

    foreach (VEC[k]) run_vec(VEC[k]);

    // R12: starts during a transfer and during the settle wait are ignored.
    ret_a = 8'h00; ret_b = 8'h5A;
    seq_base = xfer_cnt;
    dc0 = done_cnt;
    pulse_start(8'hA5);
    repeat (100) @(negedge clk);
    pulse_start(8'h00);
    while ((xfer_cnt - seq_base) < 1) @(negedge clk);
    repeat (50) @(negedge clk);
    pulse_start(8'hFF);
    wait_done(seen);
    check(lat0 == 8'hA5 && lat1 == 8'hA5, "R12", "byte unchanged by late start",
          {lat0, lat1}, 16'hA5A5);
    check(short_mask == 8'h5A && open_mask == 8'hA5, "R12", "masks of original byte",
          {short_mask, open_mask}, 16'h5AA5);
    x0 = xfer_cnt;
    repeat (1500) @(negedge clk);
    check(xfer_cnt == x0 && done_cnt == dc0 + 1, "R12", "no extra transfer or done",
          xfer_cnt - x0 + done_cnt - dc0, 1);

    // R1: reset in the middle of a transfer.
    seq_base = xfer_cnt;
    pulse_start(8'h33);
    repeat (150) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && done === 1'b0, "R1", "abort on reset",
          {spi_cs_n, spi_sclk, done}, 3'b100);
    check(short_mask == 0 && open_mask == 0, "R1", "masks cleared on reset",
          {short_mask, open_mask}, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check(spi_cs_n === 1'b1 && done === 1'b0, "R1", "stays idle after abort", {spi_cs_n, done}, 2'b10);

    // A full run after the abort still works.
    run_vec({8'h5A, 8'hFF, 8'h5B, 8'h01, 8'h00});

    check(err_r3 == 0, "R3", "lead/lag violations", err_r3, 0);
    check(err_r4 == 0, "R4", "clock phase violations", err_r4, 0);
    check(err_r5 == 0, "R5", "clock at chip-enable edge", err_r5, 0);
    check(err_r6 == 0, "R6", "settle gap violations", err_r6, 0);
    check(err_r13 == 0, "R13", "data moved off rising edge", err_r13, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule